// File: doc/BRIEF.md
# Key-Unlocked Flash Program and Erase Controller

This block sits on a simple register bus and launches single-word program and page-erase operations on an on-chip flash array. Software loads a target address and, for programming, a data word. It selects the operation and sets write-enable. It then writes a three-word key to the key register and, as the very next bus write, sets the start bit. Only then is a one-cycle request sent to the array. The start bit reads back as busy until the array returns its done pulse.

Every register has three bus addresses. The first is a plain view that replaces the contents. The second is a set view that ORs the written ones into the register. The third is a clear view that clears the bits written as ones. A start attempt that does not follow the key at once, or that finds write-enable low, or that names an unsupported operation, does not launch. Instead it sets a sticky write-error flag. A low-voltage indication sampled at completion sets a sticky low-voltage flag. Both flags clear only when a no-operation cycle is started through the same key-and-start sequence.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset every register reads zero and no flash request is issued.
- R2: Bus address bits [3:2] pick the register (0 control, 1 key, 2 address, 3 data) and bits [1:0] pick the view: 0 replaces the value, 1 ORs in the written ones, 2 clears the bits written as ones, 3 changes nothing. The address register keeps 20 bits, and its upper bits read as zero.
- R3: The control register has these fields: bit 15 busy/start, bit 14 write-enable, bit 13 write-error, bit 12 low-voltage error, bits [3:0] operation (0 none, 1 word program, 4 page erase). Write-enable and the operation field follow bus writes. Writes to bits 13 and 12 have no effect, and the key register reads zero.
- R4: A start is accepted when the key words 0x00000000, 0xAA996655, 0x556699AA have been written in that order, the start write follows them with no other bus write between, and the resulting write-enable is 1. The edge that takes the start write then raises busy and puts out a one-cycle request carrying the operation, the address and the data.
- R5: A start attempt without a completed key sequence, or with write-enable 0, issues no request, leaves busy at 0, sets write-error and disarms the key sequence.
- R6: A key word out of order, or any other bus write between the last key word and the start write, returns the unlock sequence to its first word, so a later start fails as in R5.
- R7: Busy clears on the edge that sees the done pulse. If the low-voltage input is high at that edge, the low-voltage error flag is set.
- R8: While busy, writes to the address register, the data register and the operation field are ignored.
- R9: A page-erase request carries the address with its low 14 bits cleared (16 KiB pages, 64 in all). A program request carries the address with its low 2 bits cleared.
- R10: Both error flags stay set across ordinary control writes. An accepted start with operation 0 clears both flags without a flash request.
- R11: An otherwise valid start with an operation code other than 0, 1 or 4 issues no request and sets write-error.
- R12: A start-bit write while busy has no effect: there is no second request and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Bus write strobe for one cycle |
| busAddr | input | 4 | Register select [3:2] and view select [1:0] |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Read data of the addressed register, combinational |
| flashReq | output | 1 | One-cycle operation request to the array |
| flashOp | output | 4 | Operation code of the request |
| flashAddr | output | 20 | Aligned target byte address of the request |
| flashData | output | 32 | Word to program |
| flashDone | input | 1 | One-cycle completion pulse from the array |
| flashLowVolt | input | 1 | Low-voltage indication, sampled at completion |

## Verification
A wrong unlock state is only visible at the next start write. A launch that should not have happened, or a missing one, shows on flashReq at the edge that takes that write, and the control register shows a write-error flag in the same cycle. A stale busy flag shows as a control read with bit 15 still set after the array's done pulse. It also shows as later address or data writes that fail to take effect. Flag stickiness errors appear only after an intervening control write or a no-operation cycle, so the bench reads the control register around each of those.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h0000_0000;
  localparam logic [31:0] KEY_SECOND = 32'hAA99_6655;
  localparam logic [31:0] KEY_THIRD  = 32'h5566_99AA;

  localparam logic [3:0] OP_NONE  = 4'd0;
  localparam logic [3:0] OP_PROG  = 4'd1;
  localparam logic [3:0] OP_ERASE = 4'd4;

  localparam int BIT_BUSY = 15;
  localparam int BIT_WREN = 14;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_KEY  = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  typedef enum logic [1:0] {VIEW_RAW, VIEW_SET, VIEW_CLR, VIEW_NONE} view_e;
  typedef enum logic [1:0] {KEY_WAIT0, KEY_WAIT1, KEY_WAIT2, KEY_ARMED} keyState_e;

  // bus events decoded by the datapath for the control
  typedef struct packed {
    logic        keyWr;
    logic        startReq;
    logic        otherWr;
    logic        wrenNew;
    logic [3:0]  opNew;
    logic [31:0] keyVal;
  } busEv_t;

  // strobes from the control back to the datapath
  typedef struct packed {
    logic launch;
    logic nopDone;
    logic reject;
    logic finish;
    logic lvSet;
  } ctlStrobe_t;

  function automatic logic [31:0] applyView(input logic [31:0] oldVal,
                                            input logic [31:0] wVal,
                                            input view_e view);
    case (view)
      VIEW_RAW: applyView = wVal;
      VIEW_SET: applyView = oldVal | wVal;
      VIEW_CLR: applyView = oldVal & ~wVal;
      default:  applyView = oldVal;
    endcase
  endfunction
endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     ev,
  input  logic       busy,
  input  logic       flashDone,
  input  logic       flashLowVolt,
  output ctlStrobe_t strobe
);
  keyState_e keyState, keyNext;
  logic startOk, opValid;

  always_comb begin
    opValid = (ev.opNew == OP_PROG) || (ev.opNew == OP_ERASE);
    startOk = ev.startReq && (keyState == KEY_ARMED) && ev.wrenNew;
    strobe.nopDone = startOk && (ev.opNew == OP_NONE);
    strobe.launch  = startOk && opValid;
    strobe.reject  = ev.startReq && !strobe.nopDone && !strobe.launch;
    strobe.finish  = busy && flashDone;
    strobe.lvSet   = busy && flashDone && flashLowVolt;
  end

  always_comb begin
    keyNext = keyState;
    if (ev.keyWr) begin
      keyNext = KEY_WAIT0;
      case (keyState)
        KEY_WAIT0: if (ev.keyVal == KEY_FIRST)  keyNext = KEY_WAIT1;
        KEY_WAIT1: if (ev.keyVal == KEY_SECOND) keyNext = KEY_WAIT2;
        KEY_WAIT2: if (ev.keyVal == KEY_THIRD)  keyNext = KEY_ARMED;
        default:   keyNext = KEY_WAIT0;
      endcase
    end else if (ev.startReq || ev.otherWr) begin
      keyNext = KEY_WAIT0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_WAIT0;
    else       keyState <= keyNext;
  end
endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  ctlStrobe_t        strobe,
  output busEv_t            ev,
  output logic              busy,
  output logic              lvErr,
  output logic              flashReq,
  output logic [3:0]        flashOp,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [31:0]       flashData
);
  localparam int PAD_W       = 32 - ADDR_W;
  localparam int PAGE_BASE_W = ADDR_W - PAGE_W;

  logic [1:0]        regSel;
  view_e             view;
  logic [3:0]        opReg;
  logic              wrenReg, wrErr;
  logic [ADDR_W-1:0] addrReg;
  logic [31:0]       dataReg, ctrlRaw, addrExt;
  logic [31:0]       ctrlNew, addrNew, dataNew;
  logic              writeOn, ctrlWr, addrWr, dataWr;
  logic              unusedBits;

  assign regSel  = busAddr[3:2];
  assign view    = view_e'(busAddr[1:0]);
  assign ctrlRaw = {16'h0, busy, wrenReg, wrErr, lvErr, 8'h0, opReg};
  assign addrExt = {{PAD_W{1'b0}}, addrReg};
  assign ctrlNew = applyView(ctrlRaw, busWdata, view);
  assign addrNew = applyView(addrExt, busWdata, view);
  assign dataNew = applyView(dataReg, busWdata, view);
  assign unusedBits = ^{ctrlNew[31:16], ctrlNew[13:4], addrNew[31:ADDR_W]};

  assign writeOn = busWe && (view != VIEW_NONE);
  assign ctrlWr  = writeOn && (regSel == REG_CTRL);
  assign addrWr  = writeOn && (regSel == REG_ADDR);
  assign dataWr  = writeOn && (regSel == REG_DATA);

  always_comb begin
    ev.keyWr    = writeOn && (regSel == REG_KEY);
    ev.startReq = ctrlWr && ctrlNew[BIT_BUSY] && !busy;
    ev.otherWr  = busWe && !ev.keyWr && !ev.startReq;
    ev.wrenNew  = ctrlNew[BIT_WREN];
    ev.opNew    = ctrlNew[3:0];
    ev.keyVal   = busWdata;
  end

  always_comb begin
    case (regSel)
      REG_CTRL: busRdata = ctrlRaw;
      REG_ADDR: busRdata = addrExt;
      REG_DATA: busRdata = dataReg;
      default:  busRdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= OP_NONE;
      wrenReg <= 1'b0;
      wrErr   <= 1'b0;
      lvErr   <= 1'b0;
      busy    <= 1'b0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (ctrlWr) begin
        wrenReg <= ctrlNew[BIT_WREN];
        if (!busy) opReg <= ctrlNew[3:0];
      end
      if (strobe.launch)      busy <= 1'b1;
      else if (strobe.finish) busy <= 1'b0;
      if (strobe.reject)       wrErr <= 1'b1;
      else if (strobe.nopDone) wrErr <= 1'b0;
      if (strobe.lvSet)        lvErr <= 1'b1;
      else if (strobe.nopDone) lvErr <= 1'b0;
      if (addrWr && !busy) addrReg <= addrNew[ADDR_W-1:0];
      if (dataWr && !busy) dataReg <= dataNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashReq  <= 1'b0;
      flashOp   <= OP_NONE;
      flashAddr <= '0;
      flashData <= '0;
    end else begin
      flashReq <= strobe.launch;
      if (strobe.launch) begin
        flashOp   <= ev.opNew;
        flashData <= dataReg;
        if (ev.opNew == OP_ERASE)
          flashAddr <= {addrReg[ADDR_W-1 -: PAGE_BASE_W], {PAGE_W{1'b0}}};
        else
          flashAddr <= {addrReg[ADDR_W-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              flashReq,
  output logic [3:0]        flashOp,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [31:0]       flashData,
  input  logic              flashDone,
  input  logic              flashLowVolt
);
  busEv_t     ev;
  ctlStrobe_t strobe;
  logic       busy;
  logic       lvErr;

  flash_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .busy(busy),
    .flashDone(flashDone), .flashLowVolt(flashLowVolt), .strobe(strobe)
  );

  flash_prog_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe), .ev(ev),
    .busy(busy), .lvErr(lvErr), .flashReq(flashReq), .flashOp(flashOp),
    .flashAddr(flashAddr), .flashData(flashData)
  );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashReq,
  input logic [3:0]        flashOp,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashDone,
  input logic              flashLowVolt,
  input logic              busy,
  input logic              lvErr
);
  // R4
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |=> !flashReq);
  // R4
  req_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |-> busy);
  // R7
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flashDone) |=> !busy);
  // R7
  low_volt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flashDone && flashLowVolt) |=> lvErr);
  // R9
  erase_page_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && flashOp == 4'd4) |-> (flashAddr[PAGE_W-1:0] == '0));
  // R9
  prog_word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && flashOp == 4'd1) |-> (flashAddr[1:0] == 2'b00));
  // R12
  no_req_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flashDone) |=> !flashReq);
endmodule

bind flash_prog_ctl flash_prog_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .flashReq(flashReq), .flashOp(flashOp),
  .flashAddr(flashAddr), .flashDone(flashDone), .flashLowVolt(flashLowVolt),
  .busy(busy), .lvErr(lvErr)
);

// File: tb/test_flash_prog_ctl.sv
`timescale 1ns/1ps
module test_flash_prog_ctl;
  localparam int ADDR_W = 20;
  localparam int PAGE_W = 14;
  localparam int LAT    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic flashReq;
  logic [3:0] flashOp;
  logic [ADDR_W-1:0] flashAddr;
  logic [31:0] flashData;
  logic flashDone = 1'b0;
  logic flashLowVolt = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int reqCount = 0;
  logic [3:0] lastOp;
  logic [ADDR_W-1:0] lastAddr;
  logic [31:0] lastData;
  int cnt = 0;

  always #10 clk = ~clk;

  flash_prog_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_flash_prog_ctl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .flashReq(flashReq),
    .flashOp(flashOp), .flashAddr(flashAddr), .flashData(flashData),
    .flashDone(flashDone), .flashLowVolt(flashLowVolt)
  );

  // array model with fixed latency
  always @(posedge clk) begin
    if (flashReq) begin
      cnt <= LAT;
      reqCount <= reqCount + 1;
      lastOp <= flashOp;
      lastAddr <= flashAddr;
      lastData <= flashData;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
    flashDone <= (cnt == 1) && !flashReq;
  end

  function automatic logic [31:0] viewModel(input logic [31:0] o, input logic [31:0] w, input int v);
    if (v == 0) return w;
    if (v == 1) return o | w;
    if (v == 2) return o & ~w;
    return o;
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr(input logic [3:0] op, input logic [31:0] a);
    if (op == 4'd4) return {a[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic unlock();
    wr(4'h4, 32'h0000_0000);
    wr(4'h4, 32'hAA99_6655);
    wr(4'h4, 32'h5566_99AA);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(4'h0, v);
      if (!v[15]) return;
    end
    check(1'b0, "R7 busy never cleared", v, 32'h0);
  endtask

  task automatic clearErr();
    wr(4'h0, 32'h0000_4000);
    unlock();
    wr(4'h1, 32'h0000_8000);
  endtask

  task automatic runOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
    wr(4'h8, a);
    wr(4'hC, d);
    wr(4'h0, 32'h0000_4000 | {28'h0, op});
    unlock();
    wr(4'h1, 32'h0000_8000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, expD, a, d;
    int n0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, v); check(v == 0, "R1 ctrl reset", v, 0);
    rd(4'h8, v); check(v == 0, "R1 addr reset", v, 0);
    rd(4'hC, v); check(v == 0, "R1 data reset", v, 0);
    check(flashReq == 0 && reqCount == 0, "R1 no request", {31'h0, flashReq}, 0);

    // R2 views and address width
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); check(v == 32'h000F_FFFF, "R2 addr width", v, 32'h000F_FFFF);
    wr(4'hA, 32'h0000_F00F); rd(4'h8, v); check(v == 32'h000F_0FF0, "R2 addr clear view", v, 32'h000F_0FF0);
    wr(4'hB, 32'h0000_0000); rd(4'h8, v); check(v == 32'h000F_0FF0, "R2 view 3 no effect", v, 32'h000F_0FF0);
    expD = 0;
    wr(4'hC, 32'h0);
    for (int i = 0; i < 24; i++) begin
      int vw;
      vw = $urandom_range(0, 3);
      d = $urandom;
      wr(4'hC | vw[3:0], d);
      expD = viewModel(expD, d, vw);
      rd(4'hC, v);
      check(v == expD, "R2 data random view", v, expD);
    end

    // R3 control fields, error bits not writable, key reads zero
    wr(4'h0, 32'h0000_3001); rd(4'h0, v); check(v == 32'h0000_0001, "R3 err bits ignored", v, 32'h1);
    wr(4'h1, 32'h0000_4000); rd(4'h0, v); check(v == 32'h0000_4001, "R3 wren set view", v, 32'h4001);
    wr(4'h2, 32'h0000_4000); rd(4'h0, v); check(v == 32'h0000_0001, "R3 wren clear view", v, 32'h1);
    rd(4'h4, v); check(v == 0, "R3 key reads zero", v, 0);

    // R5 start without unlock
    n0 = reqCount;
    wr(4'h0, 32'h0000_4001);
    wr(4'h1, 32'h0000_8000);
    rd(4'h0, v); check(v == 32'h0000_6001, "R5 no unlock sets wrErr", v, 32'h6001);
    check(reqCount == n0 && !flashReq, "R5 no request", reqCount, n0);
    // R10 sticky, then cleared by NOP cycle
    wr(4'h0, 32'h0000_4001); rd(4'h0, v); check(v == 32'h0000_6001, "R10 error sticky", v, 32'h6001);
    clearErr();
    rd(4'h0, v); check(v == 32'h0000_4000, "R10 nop clears", v, 32'h4000);
    check(reqCount == n0, "R10 nop no request", reqCount, n0);

    // R4 program launch
    runOp(4'd1, 32'h0001_2347, 32'hDEAD_BEEF);
    check(flashReq == 1, "R4 request pulse", {31'h0, flashReq}, 1);
    check(flashOp == 1 && flashAddr == 20'h12344 && flashData == 32'hDEAD_BEEF,
          "R9 program request fields", {12'h0, flashAddr}, 32'h12344);
    rd(4'h0, v); check(v == 32'h0000_C001, "R4 busy set", v, 32'hC001);
    check(flashReq == 0, "R4 single cycle", {31'h0, flashReq}, 0);
    waitIdle();
    rd(4'h0, v); check(v == 32'h0000_4001, "R7 busy cleared", v, 32'h4001);
    check(reqCount == n0 + 1, "R4 one request", reqCount, n0 + 1);

    // R5 wren low
    n0 = reqCount;
    wr(4'h2, 32'h0000_4000);
    unlock();
    wr(4'h1, 32'h0000_8000);
    rd(4'h0, v); check(v == 32'h0000_2001, "R5 wren low rejects", v, 32'h2001);
    check(reqCount == n0, "R5 wren low no request", reqCount, n0);
    clearErr();

    // R6 other write between key and start
    wr(4'h0, 32'h0000_4001);
    unlock();
    wr(4'h8, 32'h0000_0100);
    wr(4'h1, 32'h0000_8000);
    rd(4'h0, v); check(v == 32'h0000_6001, "R6 intervening write", v, 32'h6001);
    clearErr();
    // R6 key out of order
    wr(4'h0, 32'h0000_4001);
    wr(4'h4, 32'h0); wr(4'h4, 32'hAA99_6655); wr(4'h4, 32'h1234_5678); wr(4'h4, 32'h5566_99AA);
    wr(4'h1, 32'h0000_8000);
    rd(4'h0, v); check(v == 32'h0000_6001, "R6 wrong key", v, 32'h6001);
    check(reqCount == n0, "R6 no request", reqCount, n0);
    clearErr();
    // R6 failed start disarms: a second start also fails
    wr(4'h0, 32'h0000_4001);
    unlock();
    wr(4'h2, 32'h0000_4000);
    wr(4'h1, 32'h0000_C000);
    rd(4'h0, v); check(v == 32'h0000_6001, "R6 disarmed after write", v, 32'h6001);
    clearErr();

    // R8 and R12 writes during busy
    n0 = reqCount;
    runOp(4'd1, 32'h0000_0040, 32'h1111_2222);
    wr(4'h8, 32'h000A_BCDE);
    rd(4'h8, v); check(v == 32'h0000_0040, "R8 addr ignored busy", v, 32'h40);
    wr(4'hC, 32'h3333_4444);
    rd(4'hC, v); check(v == 32'h1111_2222, "R8 data ignored busy", v, 32'h11112222);
    wr(4'h0, 32'h0000_C004);
    rd(4'h0, v); check(v == 32'h0000_C001, "R12 start while busy ignored", v, 32'hC001);
    waitIdle();
    check(reqCount == n0 + 1, "R12 no second request", reqCount, n0 + 1);
    rd(4'h0, v); check(v == 32'h0000_4001, "R12 no error", v, 32'h4001);

    // R7 low voltage on erase, R9 page alignment
    flashLowVolt = 1'b1;
    runOp(4'd4, 32'h0005_ABCD, 32'h0);
    check(flashAddr == 20'h58000 && flashOp == 4, "R9 erase page aligned", {12'h0, flashAddr}, 32'h58000);
    waitIdle();
    flashLowVolt = 1'b0;
    rd(4'h0, v); check(v == 32'h0000_5004, "R7 low voltage flag", v, 32'h5004);
    clearErr();
    rd(4'h0, v); check(v == 32'h0000_4000, "R10 nop clears low volt", v, 32'h4000);

    // R11 unsupported op
    n0 = reqCount;
    runOp(4'd2, 32'h100, 32'h5);
    rd(4'h0, v); check(v == 32'h0000_6002, "R11 bad op rejected", v, 32'h6002);
    check(reqCount == n0, "R11 no request", reqCount, n0);
    clearErr();

    // random program/erase operations
    for (int i = 0; i < 12; i++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 1) == 0) ? 4'd1 : 4'd4;
      a = $urandom;
      d = $urandom;
      n0 = reqCount;
      runOp(op, a, d);
      waitIdle();
      check(reqCount == n0 + 1 && lastOp == op, "R4 random launch", {28'h0, lastOp}, {28'h0, op});
      check(lastAddr == expAddr(op, a), "R9 random address", {12'h0, lastAddr}, {12'h0, expAddr(op, a)});
      check(op == 4 || lastData == d, "R4 random data", lastData, d);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule